// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog for a small processor subsystem. It sits on an 8-bit register bus and counts ticks from a clock-tick input. Software must keep it alive. To do so it writes one fixed key byte to a restart register before the counter reaches its terminal count. If the count runs out, or software misuses the registers, the block sends one registered reset request to the system reset logic. It also latches a code that records why the request was raised.

A mode register selects the timeout interval. After each system reset it accepts exactly one byte-wide write. A second byte write is treated as a runaway program and causes a reset request. A static configuration input models a factory option that fixes the clock source as non-stoppable. When that input is set, the three upper mode bits always hold the pattern 0,1,1, whatever software writes to them.

Top module: `kw_watchdog`

## Requirements
- R1: After reset, `rst_req` is 0 and `rst_cause` is 0 (none). The mode register reads as `011` in bits 7:5, zeros in bits 4:SEL_W, and ones in bits SEL_W-1:0, so the longest interval is selected.
- R2: A byte-wide write of 0xAC to the restart register clears the counter. The next overflow then comes exactly 2^(N_MIN+sel) ticks later, and that write raises no request.
- R3: A byte-wide write of any value other than 0xAC to the restart register raises a reset request, with `rst_cause` = 2.
- R4: A single-bit write (`bus_bit`=1) to the restart register raises a reset request with `rst_cause` = 3, whatever the data, including 0xAC.
- R5: Reading the restart register always returns 0x9A, whatever was written to it.
- R6: The first byte-wide write to the mode register after reset is stored. It clears the counter, and its bits SEL_W-1:0 (sel) select the interval.
- R7: Any later byte-wide write to the mode register before the next reset raises a reset request with `rst_cause` = 4. The stored mode stays unchanged.
- R8: A single-bit write to the mode register is ignored. It changes no state, raises no request and does not use up the single allowed write.
- R9: When `nonstop_fixed`=1, mode bits 7:5 are stored as 0,1,1 regardless of the written data. When `nonstop_fixed`=0, all eight written bits are stored.
- R10: The counter overflows on the 2^(N_MIN+sel)-th tick after it is cleared. An overflow raises a reset request with `rst_cause` = 1, and the counter starts again from zero.
- R11: The counter advances only in cycles where `tick`=1.
- R12: `rst_req` is a registered pulse that is high only in the cycle after a triggering event. A system reset clears the single-write lock, so the mode register can be written again.
- R13: If a register fault and an overflow happen in the same cycle, the fault cause is recorded. If a valid 0xAC restart lands on the overflowing tick, the overflow is suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| tick | input | 1 | Count-enable tick from the selected clock source |
| nonstop_fixed | input | 1 | Static option: clock source fixed as non-stoppable |
| bus_wr | input | 1 | Register write strobe |
| bus_bit | input | 1 | Marks the write as a single-bit manipulation |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| rst_req | output | 1 | One-cycle internal reset request |
| rst_cause | output | 3 | Cause of the last request: 0 none, 1 overflow, 2 bad key, 3 bit access, 4 second mode write |

## Verification
The assertions check on every cycle that:
- a locked mode register never changes;
- single-bit mode writes leave the mode register alone;
- the counter never passes the selected terminal count and holds still without a tick;
- every fault or overflow produces a request in the following cycle with the matching cause.

Only the bench scenarios can show the rest:
- the exact tick count to overflow for every interval setting, with and without a restart;
- the sweep of all 256 restart-register data values;
- coincident fault-and-overflow cases;
- the restored write-once capability after a system reset.

// File: rtl/wdt_kp_pkg.sv
`timescale 1ns/1ps
package wdt_kp_pkg;
   typedef enum logic [2:0] {
      CZ_NONE       = 3'd0,
      CZ_OVERFLOW   = 3'd1,
      CZ_BAD_KEY    = 3'd2,
      CZ_BIT_KEY    = 3'd3,
      CZ_MODE_AGAIN = 3'd4
   } cause_e;

   // Mode register value after reset: fixed-source pattern on top, longest interval below.
   function automatic logic [7:0] mode_reset_val(input int sel_w);
      logic [7:0] v;
      v = 8'h60;
      for (int i = 0; i < sel_w; i++) v[i] = 1'b1;
      return v;
   endfunction
endpackage

// File: rtl/kwd_regs.sv
`timescale 1ns/1ps
module kwd_regs import wdt_kp_pkg::*; #(
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] MODE_ADDR = 'h10,
   parameter logic [ADDR_W-1:0] KEY_ADDR  = 'h11,
   parameter logic [7:0]        KEY_VAL   = 8'hAC,
   parameter logic [7:0]        KEY_READ  = 8'h9A,
   parameter int                SEL_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nonstop,
   input  logic              bus_wr,
   input  logic              bus_bit,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic [SEL_W-1:0]  sel,
   output logic              restart,
   output logic              fault,
   output cause_e            fault_cause
);
   localparam logic [7:0] MODE_RST = mode_reset_val(SEL_W);

   logic [7:0] mode_q;
   logic       once_q;
   logic       hit_key, hit_mode, key_ok, mode_take;
   logic [7:0] mode_new;

   assign hit_key   = bus_wr && (bus_addr == KEY_ADDR);
   assign hit_mode  = bus_wr && (bus_addr == MODE_ADDR);
   assign key_ok    = hit_key && !bus_bit && (bus_wdata == KEY_VAL);
   assign mode_take = hit_mode && !bus_bit && !once_q;
   assign mode_new  = nonstop ? {3'b011, bus_wdata[4:0]} : bus_wdata;
   assign restart   = key_ok || mode_take;
   assign sel       = mode_q[SEL_W-1:0];

   always_comb begin
      fault       = 1'b0;
      fault_cause = CZ_NONE;
      if (hit_key && bus_bit) begin
         fault       = 1'b1;
         fault_cause = CZ_BIT_KEY;
      end else if (hit_key && (bus_wdata != KEY_VAL)) begin
         fault       = 1'b1;
         fault_cause = CZ_BAD_KEY;
      end else if (hit_mode && !bus_bit && once_q) begin
         fault       = 1'b1;
         fault_cause = CZ_MODE_AGAIN;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RST;
         once_q <= 1'b0;
      end else if (mode_take) begin
         mode_q <= mode_new;
         once_q <= 1'b1;
      end
   end

   always_comb begin
      if (bus_addr == KEY_ADDR)       bus_rdata = KEY_READ;
      else if (bus_addr == MODE_ADDR) bus_rdata = mode_q;
      else                            bus_rdata = 8'h00;
   end

   // R7
   mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(once_q) |-> $stable(mode_q));
   // R8
   mode_bit_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_mode && bus_bit) |=> $stable(mode_q));
   // R9
   nonstop_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_take && nonstop) |=> (mode_q[7:5] == 3'b011));
endmodule

// File: rtl/kwd_count.sv
`timescale 1ns/1ps
module kwd_count #(
   parameter int N_MIN = 10,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   input  logic [SEL_W-1:0] sel,
   output logic             ovf
);
   localparam int N_SEL = 2 ** SEL_W;
   localparam int CW    = N_MIN + N_SEL - 1;

   logic [CW-1:0] term_tab [N_SEL];
   logic [CW-1:0] term;
   logic [CW-1:0] cnt_q;

   for (genvar gi = 0; gi < N_SEL; gi++) begin : g_term
      assign term_tab[gi] = {CW{1'b1}} >> (CW - N_MIN - gi);
   end

   assign term = term_tab[sel];
   assign ovf  = tick && !restart && (cnt_q == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (restart)  cnt_q <= '0;
      else if (ovf)      cnt_q <= '0;
      else if (tick)     cnt_q <= cnt_q + 1'b1;
   end

   // R10
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= term);
   // R2
   restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0));
   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !restart) |=> $stable(cnt_q));
endmodule

// File: rtl/kwd_req.sv
`timescale 1ns/1ps
module kwd_req import wdt_kp_pkg::*; (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   fault,
   input  cause_e fault_cause,
   input  logic   ovf,
   output logic   rst_req,
   output cause_e cause
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req <= 1'b0;
         cause   <= CZ_NONE;
      end else begin
         rst_req <= fault || ovf;
         if (fault)    cause <= fault_cause;
         else if (ovf) cause <= CZ_OVERFLOW;
      end
   end

   // R3
   fault_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> (rst_req && (cause == $past(fault_cause))));
   // R13
   ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !fault) |=> (rst_req && (cause == CZ_OVERFLOW)));
   // R12
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault && !ovf) |=> !rst_req);
endmodule

// File: rtl/kw_watchdog.sv
`timescale 1ns/1ps
module kw_watchdog import wdt_kp_pkg::*; #(
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] MODE_ADDR = 'h10,
   parameter logic [ADDR_W-1:0] KEY_ADDR  = 'h11,
   parameter logic [7:0]        KEY_VAL   = 8'hAC,
   parameter logic [7:0]        KEY_READ  = 8'h9A,
   parameter int                N_MIN     = 10,
   parameter int                SEL_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              nonstop_fixed,
   input  logic              bus_wr,
   input  logic              bus_bit,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              rst_req,
   output logic [2:0]        rst_cause
);
   localparam int CW = N_MIN + (2 ** SEL_W) - 1;

   if (SEL_W < 1 || SEL_W > 5) begin : g_bad_sel
      $error("SEL_W must lie in 1..5");
   end
   if (N_MIN < 1 || CW > 32) begin : g_bad_cw
      $error("N_MIN must be at least 1 and the counter at most 32 bits");
   end
   if (MODE_ADDR == KEY_ADDR) begin : g_bad_map
      $error("mode and restart registers need distinct addresses");
   end

   logic [SEL_W-1:0] sel;
   logic             restart, fault, ovf;
   cause_e           fault_cause, cause;

   kwd_regs #(
      .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .KEY_ADDR(KEY_ADDR),
      .KEY_VAL(KEY_VAL), .KEY_READ(KEY_READ), .SEL_W(SEL_W)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .nonstop(nonstop_fixed),
      .bus_wr(bus_wr), .bus_bit(bus_bit), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sel(sel),
      .restart(restart), .fault(fault), .fault_cause(fault_cause)
   );

   kwd_count #(.N_MIN(N_MIN), .SEL_W(SEL_W)) i_count (
      .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
      .sel(sel), .ovf(ovf)
   );

   kwd_req i_req (
      .clk(clk), .rst_n(rst_n), .fault(fault), .fault_cause(fault_cause),
      .ovf(ovf), .rst_req(rst_req), .cause(cause)
   );

   assign rst_cause = cause;
endmodule

// File: tb/test_kw_watchdog.sv
`timescale 1ns/1ps
module test_kw_watchdog;
   localparam logic [7:0] MA = 8'h10;
   localparam logic [7:0] KA = 8'h11;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       nonstop_fixed = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_bit = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       rst_req;
   logic [2:0] rst_cause;
   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   kw_watchdog #(.ADDR_W(8), .MODE_ADDR(MA), .KEY_ADDR(KA), .N_MIN(2), .SEL_W(2)) i_kw_watchdog (
      .clk(clk), .rst_n(rst_n), .tick(tick), .nonstop_fixed(nonstop_fixed),
      .bus_wr(bus_wr), .bus_bit(bus_bit), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req),
      .rst_cause(rst_cause)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic ns);
      @(negedge clk);
      rst_n = 1'b0; tick = 1'b0; bus_wr = 1'b0; bus_bit = 1'b0;
      nonstop_fixed = ns;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // One bus write; returns at the negedge after the write edge.
   task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic b, input logic t);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_bit = b; tick = t;
      @(negedge clk);
      bus_wr = 1'b0; bus_bit = 1'b0; tick = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic run_ticks(input int n);
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   // Ticks every cycle until a request; returns the number of ticks.
   task automatic run_to_req(output int n);
      n = 0;
      @(negedge clk);
      tick = 1'b1;
      while (n < 100) begin
         @(negedge clk);
         n++;
         if (rst_req) break;
      end
      tick = 1'b0;
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] d;
      int n;

      // R1 reset state, R5 restart register readback
      do_reset(1'b0);
      chk("R1 req", rst_req, 0);
      chk("R1 cause", rst_cause, 0);
      rd(MA, d); chk("R1 mode", d, 8'h63);
      rd(KA, d); chk("R5 read", d, 8'h9A);

      // R10 default interval = 2^(2+3) = 32
      run_to_req(n);
      chk("R10 default ticks", n, 32);
      chk("R10 cause", rst_cause, 1);
      @(negedge clk); chk("R12 pulse width", rst_req, 0);

      // R6 R9 R10 R7 sweep over every interval and both option settings
      for (int ns = 0; ns < 2; ns++) begin
         for (int s = 0; s < 4; s++) begin
            do_reset(ns[0]);
            wr(MA, {3'b101, 3'b100, s[1:0]}, 1'b0, 1'b0);
            chk("R6 no req", rst_req, 0);
            rd(MA, d);
            chk("R9 mode", d, ns ? {3'b011, 3'b100, s[1:0]} : {3'b101, 3'b100, s[1:0]});
            run_to_req(n);
            chk("R10 ticks", n, 1 << (2 + s));
            chk("R10 cause", rst_cause, 1);
            wr(MA, 8'h00, 1'b0, 1'b0);
            chk("R7 req", rst_req, 1);
            chk("R7 cause", rst_cause, 4);
            @(negedge clk); chk("R12 pulse", rst_req, 0);
            rd(MA, d);
            chk("R7 mode kept", d, ns ? {3'b011, 3'b100, s[1:0]} : {3'b101, 3'b100, s[1:0]});
         end
      end

      // R8 bit write to mode ignored, lock not used up; R12 lock cleared by reset
      do_reset(1'b0);
      wr(MA, 8'h00, 1'b1, 1'b0);
      chk("R8 no req", rst_req, 0);
      rd(MA, d); chk("R8 mode", d, 8'h63);
      wr(MA, 8'h01, 1'b0, 1'b0);
      chk("R12 writable after reset", rst_req, 0);
      rd(MA, d); chk("R8 later write", d, 8'h01);
      run_to_req(n); chk("R8 interval", n, 8);

      // R2 restart with key
      do_reset(1'b0);
      wr(MA, 8'h01, 1'b0, 1'b0);
      run_ticks(5);
      wr(KA, 8'hAC, 1'b0, 1'b0);
      chk("R2 no req", rst_req, 0);
      rd(KA, d); chk("R5 read after key", d, 8'h9A);
      run_to_req(n); chk("R2 ticks", n, 8);

      // R11 no count without tick
      do_reset(1'b0);
      wr(MA, 8'h00, 1'b0, 1'b0);
      repeat (20) @(negedge clk);
      chk("R11 idle", rst_req, 0);
      run_to_req(n); chk("R11 ticks", n, 4);

      // R3 exhaustive restart data sweep
      do_reset(1'b0);
      for (int v = 0; v < 256; v++) begin
         wr(KA, v[7:0], 1'b0, 1'b0);
         chk("R3 req", rst_req, (v != 8'hAC) ? 1 : 0);
         if (v != 8'hAC) chk("R3 cause", rst_cause, 2);
      end
      rd(KA, d); chk("R5 read after sweep", d, 8'h9A);

      // R4 bit access to restart register
      wr(KA, 8'hAC, 1'b1, 1'b0);
      chk("R4 req", rst_req, 1);
      chk("R4 cause", rst_cause, 3);
      wr(KA, 8'h00, 1'b1, 1'b0);
      chk("R4 cause any data", rst_cause, 3);

      // R13 coincident fault and overflow, then key on the overflowing tick
      do_reset(1'b0);
      wr(MA, 8'h00, 1'b0, 1'b0);
      run_ticks(3);
      wr(KA, 8'h00, 1'b0, 1'b1);
      chk("R13 req", rst_req, 1);
      chk("R13 fault wins", rst_cause, 2);
      run_ticks(3);
      wr(KA, 8'hAC, 1'b0, 1'b1);
      chk("R13 key suppresses", rst_req, 0);
      run_to_req(n); chk("R13 ticks", n, 4);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule